// File: doc/BRIEF.md
# HDB3 Line Decoder with Code-Error Monitor

This block receives an E1 line as two pulse rails, one for positive marks and one for negative marks, together with the recovered bit clock, and turns it into a single NRZ bit stream. While it decodes, it removes the four-zero substitutions (`000V` and `B00V`) that an HDB3 encoder inserts. Each output bit is released from a short fixed pipeline, so a substitution can still be undone before any of its bits leave the block.

A code monitor runs next to the decoder. It checks the line against one of four host-selected rules and adds each offending bit to a saturating error counter. The host reads the counter through a read strobe. A sticky overflow flag drives an interrupt line that the host can mask. Decoding can be switched off. The block then passes the positive rail through as plain NRZ, ignores the negative rail and counts no errors. One configuration bit selects whether the rails are sampled on the rising or the falling clock edge.

Top module: `hdb3_rx_mon`

## Requirements
- R1: After reset, `nrz_out`, `err_count`, `ovf_flag` and `irq` are all 0.
- R2: With decoding on, a bit that carries a pulse on either rail decodes to 1 and an empty bit decodes to 0. A bit sampled at clock edge k appears on `nrz_out` after edge k+4.
- R3: A violation is a mark with the same polarity as the previous mark. When a violation follows two zero bits, it is a substitution. `000V` and `B00V` both decode to four zeros: the V is removed, and for `B00V` the B mark three bits earlier is removed as well.
- R4: With `cfg_dec_en`=0, `nrz_out` carries `line_pos` with the R2 latency. `line_neg` has no effect and no error is counted in any rule.
- R5: With `cfg_rule`=0, no error is counted.
- R6: With `cfg_rule`=1, a violation that does not follow two zero bits counts one error.
- R7: With `cfg_rule`=2, a violation with the same polarity as the previous violation counts one error. The first violation after reset is exempt.
- R8: With `cfg_rule`=3, a bit counts one error when the R6 rule fires, when the R7 rule fires, or when it is the fourth (or a later) consecutive zero bit on the line.
- R9: A bit with pulses on both rails is taken as a positive mark. In rules 1 to 3 it counts one error. No bit ever counts more than one error.
- R10: Each erroneous bit adds 1 to `err_count`. The count saturates at 0xFFFF. An error that arrives while the count is 0xFFFF sets the sticky `ovf_flag`.
- R11: `irq` is 1 exactly when `ovf_flag` is 1 and `cfg_irq_mask` is 0.
- R12: `err_count` shows the current count. A one-cycle `host_rd` pulse clears the count and `ovf_flag` at the next edge. If an error arrives in that same cycle, the count restarts at 1 instead of 0.
- R13: With `cfg_fall_edge`=1, the rails are taken at the falling clock edge. With `cfg_fall_edge`=0, they are taken at the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous active-high reset |
| line_pos | input | 1 | Positive pulse rail, or NRZ data in bypass |
| line_neg | input | 1 | Negative pulse rail |
| cfg_dec_en | input | 1 | 1 = HDB3 decoding, 0 = NRZ bypass |
| cfg_fall_edge | input | 1 | 1 = sample the rails on the falling edge |
| cfg_rule | input | 2 | Code-error rule select (0..3) |
| cfg_irq_mask | input | 1 | 1 = mask the overflow interrupt |
| host_rd | input | 1 | Read strobe that clears the count and overflow flag |
| nrz_out | output | 1 | Decoded NRZ bit |
| err_count | output | CNT_W | Saturating error count |
| ovf_flag | output | 1 | Sticky counter overflow |
| irq | output | 1 | Unmasked overflow interrupt |

## Verification
Long pseudo-random data streams with many zeros are HDB3-encoded in the bench and fed in under each checking rule and both sampling edges. These runs show that substitutions are removed without disturbing the data and that legal line code never counts as an error. Short hand-built line sequences are each run under every rule. Each sequence holds exactly one kind of fault: a same-polarity mark pair, two violations of equal polarity, four empty bits, or a pulse on both rails. The resulting counts show which rule catches which fault. A signal that changes between the falling and the next rising edge shows which edge samples the rails. A run of more than 65,536 error bits checks exact counting, saturation, the interrupt mask and a read that coincides with an error.

// File: rtl/hdb3_pkg.sv
package hdb3_pkg;
  // Zero-run length that HDB3 substitutes; also the decode window depth.
  localparam int RUN = 4;

  typedef enum logic [1:0] {
    RULE_OFF  = 2'd0,
    RULE_SAME = 2'd1,
    RULE_ALT  = 2'd2,
    RULE_ALL  = 2'd3
  } rule_e;
endpackage

// File: rtl/hdb3_sampler.sv
module hdb3_sampler (
  input  logic clk,
  input  logic rst,
  input  logic fall_sel,
  input  logic dec_en,
  input  logic line_pos,
  input  logic line_neg,
  output logic smp_pos,
  output logic smp_neg
);
  logic n_pos, n_neg;

  // Falling-edge capture, handed to the rising-edge domain one half cycle later.
  always_ff @(negedge clk) begin
    if (rst) begin
      n_pos <= 1'b0;
      n_neg <= 1'b0;
    end else begin
      n_pos <= line_pos;
      n_neg <= line_neg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_pos <= 1'b0;
      smp_neg <= 1'b0;
    end else begin
      smp_pos <= fall_sel ? n_pos : line_pos;
      smp_neg <= dec_en & (fall_sel ? n_neg : line_neg);
    end
  end
endmodule

// File: rtl/hdb3_decoder.sv
module hdb3_decoder
  import hdb3_pkg::*;
#(
  parameter int WIN = RUN
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  dec_en,
  input  rule_e rule,
  input  logic  smp_pos,
  input  logic  smp_neg,
  output logic  nrz_bit,
  output logic  err_hit
);
  localparam int HIST = WIN - 1;

  logic [WIN-1:0]  dly, dly_n;   // decoded bits, [0] newest
  logic [HIST-1:0] raw, raw_n;   // raw line marks, [0] newest
  logic mark_seen, last_pol, v_seen, last_vpol;

  logic mark, pol, both, viol, two_zero, three_zero, sub_any, sub_b, bit_in;
  logic e_same, e_alt, e_zero, e_both;

  always_comb begin
    mark       = smp_pos | smp_neg;
    pol        = smp_pos;                 // both rails -> positive
    both       = smp_pos & smp_neg;
    viol       = dec_en & mark & mark_seen & (pol == last_pol);
    two_zero   = ~raw[0] & ~raw[1];
    three_zero = ~|raw;
    sub_any    = viol & two_zero;
    sub_b      = sub_any & raw[HIST-1];
    bit_in     = dec_en ? (mark & ~sub_any) : smp_pos;

    dly_n          = {dly[WIN-2:0], bit_in};
    dly_n[WIN-1]   = dly[WIN-2] & ~sub_b;
    raw_n          = {raw[HIST-2:0], mark};

    e_same = viol & ~two_zero;
    e_alt  = viol & v_seen & (pol == last_vpol);
    e_zero = dec_en & ~mark & three_zero;
    e_both = dec_en & both;

    case (rule)
      RULE_SAME: err_hit = e_same | e_both;
      RULE_ALT:  err_hit = e_alt | e_both;
      RULE_ALL:  err_hit = e_same | e_alt | e_zero | e_both;
      default:   err_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dly       <= '0;
      raw       <= '1;
      mark_seen <= 1'b0;
      last_pol  <= 1'b0;
      v_seen    <= 1'b0;
      last_vpol <= 1'b0;
    end else begin
      dly <= dly_n;
      raw <= raw_n;
      if (mark) begin
        mark_seen <= 1'b1;
        last_pol  <= pol;
      end
      if (viol) begin
        v_seen    <= 1'b1;
        last_vpol <= pol;
      end
    end
  end

  assign nrz_bit = dly[WIN-1];
endmodule

// File: rtl/hdb3_err_cnt.sv
module hdb3_err_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             rd,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (rd) begin
      cnt <= CNT_W'(hit);
      ovf <= 1'b0;
    end else if (hit) begin
      if (cnt == CNT_MAX) ovf <= 1'b1;
      else                cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hdb3_rx_mon.sv
module hdb3_rx_mon
  import hdb3_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_pos,
  input  logic             line_neg,
  input  logic             cfg_dec_en,
  input  logic             cfg_fall_edge,
  input  logic [1:0]       cfg_rule,
  input  logic             cfg_irq_mask,
  input  logic             host_rd,
  output logic             nrz_out,
  output logic [CNT_W-1:0] err_count,
  output logic             ovf_flag,
  output logic             irq
);
  logic smp_pos, smp_neg, err_hit;

  hdb3_sampler u_smp (
    .clk      (clk),
    .rst      (rst),
    .fall_sel (cfg_fall_edge),
    .dec_en   (cfg_dec_en),
    .line_pos (line_pos),
    .line_neg (line_neg),
    .smp_pos  (smp_pos),
    .smp_neg  (smp_neg)
  );

  hdb3_decoder #(.WIN(RUN)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .dec_en  (cfg_dec_en),
    .rule    (rule_e'(cfg_rule)),
    .smp_pos (smp_pos),
    .smp_neg (smp_neg),
    .nrz_bit (nrz_out),
    .err_hit (err_hit)
  );

  hdb3_err_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .hit (err_hit),
    .rd  (host_rd),
    .cnt (err_count),
    .ovf (ovf_flag)
  );

  assign irq = ovf_flag & ~cfg_irq_mask;
endmodule

// File: rtl/hdb3_rx_mon_chk.sv
module hdb3_rx_mon_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_dec_en,
  input logic [1:0]       cfg_rule,
  input logic             host_rd,
  input logic [CNT_W-1:0] err_count,
  input logic             ovf_flag
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assert_count_monotone_R10: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> err_count >= $past(err_count));

  assert_ovf_only_at_max_R10: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |-> err_count == CNT_MAX);

  assert_ovf_rise_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> $past(err_count) == CNT_MAX);

  assert_read_clears_R12: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> (err_count <= 1) && !ovf_flag);

  assert_rule_off_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_rule == 2'd0 && !host_rd) |=> $stable(err_count));

  assert_bypass_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_dec_en && !host_rd) |=> $stable(err_count));
endmodule

bind hdb3_rx_mon hdb3_rx_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_dec_en (cfg_dec_en),
  .cfg_rule   (cfg_rule),
  .host_rd    (host_rd),
  .err_count  (err_count),
  .ovf_flag   (ovf_flag)
);

// File: tb/hdb3_rx_mon_tb.sv
`timescale 1ns/1ps
module hdb3_rx_mon_tb;
  localparam int CNT_W = 16;
  localparam int N = 400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_pos = 1'b0, line_neg = 1'b0;
  logic cfg_dec_en = 1'b1, cfg_fall_edge = 1'b0, cfg_irq_mask = 1'b0, host_rd = 1'b0;
  logic [1:0] cfg_rule = 2'd0;
  logic nrz_out, ovf_flag, irq;
  logic [CNT_W-1:0] err_count;

  int checks = 0;
  int fails = 0;

  logic dat [N];
  logic ep  [N];
  logic en  [N];

  always #2 clk = ~clk;

  hdb3_rx_mon #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .line_pos(line_pos), .line_neg(line_neg),
    .cfg_dec_en(cfg_dec_en), .cfg_fall_edge(cfg_fall_edge), .cfg_rule(cfg_rule),
    .cfg_irq_mask(cfg_irq_mask), .host_rd(host_rd), .nrz_out(nrz_out),
    .err_count(err_count), .ovf_flag(ovf_flag), .irq(irq)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Leaves the bench 1 ns after an edge with rst still high.
  task automatic do_reset(input logic [1:0] rule, input logic dec, input logic fall);
    tick();
    rst = 1'b1;
    cfg_rule = rule;
    cfg_dec_en = dec;
    cfg_fall_edge = fall;
    line_pos = 1'b0;
    line_neg = 1'b0;
    host_rd = 1'b0;
    repeat (3) tick();
  endtask

  task automatic encode();
    int i = 0;
    int pulses = 0;
    logic lastp = 1'b1;
    while (i < N) begin
      if (i + 3 < N && !dat[i] && !dat[i+1] && !dat[i+2] && !dat[i+3]) begin
        for (int k = 0; k < 4; k++) begin ep[i+k] = 0; en[i+k] = 0; end
        if (pulses % 2 == 0) begin
          lastp = ~lastp;
          ep[i] = lastp; en[i] = ~lastp;
        end
        ep[i+3] = lastp; en[i+3] = ~lastp;
        pulses = 0;
        i += 4;
      end else begin
        if (dat[i]) begin
          lastp = ~lastp;
          ep[i] = lastp; en[i] = ~lastp;
          pulses++;
        end else begin
          ep[i] = 0; en[i] = 0;
        end
        i++;
      end
    end
  endtask

  task automatic fill(input logic [15:0] seed);
    logic [15:0] lf = seed;
    for (int i = 0; i < N; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      dat[i] = (i < N / 2) ? (lf[0] & lf[3]) : lf[5];
    end
    dat[0] = 1'b1;
  endtask

  // R2, R3: valid HDB3 stream decodes to its data and counts no error.
  task automatic run_stream(input logic [15:0] seed, input logic [1:0] rule, input logic fall);
    fill(seed);
    encode();
    do_reset(rule, 1'b1, fall);
    for (int j = 0; j < N + 6; j++) begin
      rst = 1'b0;
      line_pos = (j < N) ? ep[j] : 1'b0;
      line_neg = (j < N) ? en[j] : 1'b0;
      if (j >= 5 && j - 5 < N)
        chk(nrz_out == dat[j-5], "R2/R3 decoded bit", nrz_out, dat[j-5]);
      if (j == N)
        chk(err_count == 0, "R6/R7/R8 legal stream error count", err_count, 0);
      tick();
    end
  endtask

  // R4: bypass passes line_pos, ignores line_neg, counts nothing.
  task automatic run_bypass(input logic [15:0] seed);
    fill(seed);
    for (int i = 0; i < N; i++) en[i] = dat[(i * 7) % N];
    do_reset(2'd3, 1'b0, 1'b0);
    for (int j = 0; j < N + 6; j++) begin
      rst = 1'b0;
      line_pos = (j < N) ? dat[j] : 1'b0;
      line_neg = (j < N) ? en[j] : 1'b0;
      if (j >= 5 && j - 5 < N)
        chk(nrz_out == dat[j-5], "R4 bypass bit", nrz_out, dat[j-5]);
      tick();
    end
    chk(err_count == 0, "R4 bypass error count", err_count, 0);
  endtask

  // R13: value changes between falling and next rising edge.
  task automatic run_edge(input logic fall);
    fill(16'h3C5A);
    do_reset(2'd0, 1'b0, fall);
    for (int j = 0; j < 60; j++) begin
      rst = 1'b0;
      line_pos = dat[j];
      if (j >= 5)
        chk(nrz_out == (fall ? dat[j-5] : ~dat[j-5]), "R13 sampling edge", nrz_out,
            fall ? dat[j-5] : ~dat[j-5]);
      #2;
      line_pos = ~dat[j];
      tick();
    end
  endtask

  // Symbols: 0 zero, 1 positive, 2 negative, 3 both rails.
  task automatic run_seq(input logic [15:0] code, input int len, input logic [1:0] rule,
                         input int exp, input string tag);
    do_reset(rule, 1'b1, 1'b0);
    for (int i = 0; i < len + 2; i++) begin
      rst = 1'b0;
      line_pos = (i < len) ? code[2*i] : 1'b0;
      line_neg = (i < len) ? code[2*i+1] : 1'b0;
      tick();
    end
    chk(err_count == exp, tag, err_count, exp);
  endtask

  task automatic seq_all(input logic [15:0] code, input int len, input logic [7:0] exps,
                         input string tag);
    for (int m = 0; m < 4; m++)
      run_seq(code, len, m[1:0], int'(exps[2*m +: 2]), $sformatf("%s rule%0d", tag, m));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk(nrz_out == 0, "R1 reset nrz_out", nrz_out, 0);
    chk(err_count == 0, "R1 reset err_count", err_count, 0);
    chk(ovf_flag == 0, "R1 reset ovf_flag", ovf_flag, 0);
    chk(irq == 0, "R1 reset irq", irq, 0);

    run_stream(16'hACE1, 2'd3, 1'b0);
    run_stream(16'h1D2B, 2'd1, 1'b0);
    run_stream(16'h7777, 2'd2, 1'b0);
    run_stream(16'hBEEF, 2'd3, 1'b1);
    run_bypass(16'h5A5A);
    run_edge(1'b0);
    run_edge(1'b1);

    // expected counts packed as {rule3, rule2, rule1, rule0}
    seq_all(16'h0059, 4, {2'd1, 2'd0, 2'd1, 2'd0}, "R6 same-polarity pair");
    seq_all(16'h0041, 4, {2'd0, 2'd0, 2'd0, 2'd0}, "R3 B00V exempt");
    seq_all(16'h8241, 8, {2'd0, 2'd0, 2'd0, 2'd0}, "R7 alternating violations");
    seq_all(16'h4041, 8, {2'd1, 2'd1, 2'd0, 2'd0}, "R7 repeated violation polarity");
    seq_all(16'h0801, 6, {2'd1, 2'd0, 2'd0, 2'd0}, "R8 four zeros");
    seq_all(16'h002D, 3, {2'd1, 2'd1, 2'd1, 2'd0}, "R9 both rails");

    // R10, R11, R12: counting, saturation, mask, read
    do_reset(2'd1, 1'b1, 1'b0);
    cfg_irq_mask = 1'b0;
    for (int j = 0; j < 65546; j++) begin
      rst = 1'b0;
      line_pos = 1'b1;
      line_neg = 1'b1;
      if (j == 1000) chk(err_count == 999, "R10 exact count", err_count, 999);
      if (j == 1000) chk(ovf_flag == 0, "R10 no early overflow", ovf_flag, 0);
      tick();
    end
    chk(err_count == 16'hFFFF, "R10 saturation", err_count, 16'hFFFF);
    chk(ovf_flag == 1, "R10 overflow flag", ovf_flag, 1);
    chk(irq == 1, "R11 irq unmasked", irq, 1);
    cfg_irq_mask = 1'b1;
    #1;
    chk(irq == 0, "R11 irq masked", irq, 0);
    cfg_irq_mask = 1'b0;
    #1;
    chk(irq == 1, "R11 irq unmask again", irq, 1);
    host_rd = 1'b1;
    tick();
    host_rd = 1'b0;
    chk(err_count == 1, "R12 read with coincident error", err_count, 1);
    chk(ovf_flag == 0, "R12 read clears overflow", ovf_flag, 0);
    chk(irq == 0, "R11 irq after clear", irq, 0);
    line_pos = 1'b0;
    line_neg = 1'b0;
    repeat (6) tick();
    host_rd = 1'b1;
    tick();
    host_rd = 1'b0;
    chk(err_count == 0, "R12 quiet read clears", err_count, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule